// File: doc/BRIEF.md
# Floating-Point to Integer Converter

This unit turns a binary64 floating-point operand into a signed or unsigned integer of 32 or 64 bits. The answer always comes back on a 64-bit result bus. It has one register stage: an operand presented with `in_valid` in one cycle yields its result, write-enable and status flags on the outputs after the next rising clock edge. The operand can also be read as a single-precision value held in double format. In that case the fraction bits that a single-precision number cannot carry are dropped before conversion.

Three behaviours handle NaN and out-of-range operands, chosen by the upper two bits of the mode selector:

- **Hardware saturation.** NaN gives the most negative integer of the type.
- **Language saturation.** NaN gives zero.
- **Modular wrap.** NaN and infinities give zero. Every other value is reduced modulo 2^N, where N is the width of the integer type.

The lowest mode bit forces truncation. Otherwise the dynamic rounding mode input applies.

The status outputs are inexact, rounded-up, signalling-NaN invalid, conversion invalid, integer overflow and illegal mode. With the invalid trap enabled, an invalid conversion suppresses the write to the destination.

Top module: `fp2int_conv`

## Requirements
- R1: An operand accepted with `in_valid` high produces `out_valid` high after the next rising edge, and `wr_en` is never high without `out_valid`. After synchronous reset `out_valid`, `wr_en`, `result` and all flags are 0.
- R2: `int_type` encodes 0 = signed 32-bit, 1 = unsigned 32-bit, 2 = signed 64-bit, 3 = unsigned 64-bit. A 32-bit result is sign-extended to 64 bits for the signed type and zero-extended for the unsigned type.
- R3: When `cvt_mode[0]` is 1, rounding is toward zero. Otherwise `rnd_mode` selects it: 00 nearest-even, 01 toward zero, 10 toward +infinity, 11 toward -infinity.
- R4: For `cvt_mode` 000/001, NaN gives the minimum of the type, a rounded value above the maximum gives the maximum, and a rounded value below the minimum gives the minimum.
- R5: For `cvt_mode` 010/011, NaN gives 0 and out-of-range values saturate as in R4.
- R6: For `cvt_mode` 100/101, NaN and infinities give 0. Any other rounded value is taken modulo 2^N, and its low N bits are read as signed or unsigned according to the type.
- R7: `cvt_mode` 110/111 sets `illegal_mode`, keeps `wr_en` low, clears every other flag and returns a result of 0.
- R8: `flag_inexact` is set when the rounded integer differs from the operand. `flag_rndup` is set when rounding increased the magnitude. Both are 0 for NaN, and for out-of-range results in the saturating modes.
- R9: `flag_snan` is set for a signalling NaN, meaning a NaN whose fraction bit 51 is 0. `flag_cvt_inv` is set for any NaN, and for an out-of-range value in the two saturating modes.
- R10: `ovf` is set only when `ovf_en` was 1. It then reports a NaN operand, a rounded value outside the type range, or an inexact conversion.
- R11: When `inv_en` is 1 and either invalid flag is set, `wr_en` is 0 and `flag_inexact`, `flag_rndup` and `ovf` are 0.
- R12: When `single_sel` is 1, fraction bits 28:0 of a non-NaN operand are ignored.
- R13: An in-range operand converts exactly to its rounded value. This includes -0.0 giving 0, and the type minimum giving itself with no flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand and controls are valid this cycle |
| op_bits | input | 64 | binary64 operand |
| single_sel | input | 1 | Interpret the operand as single precision |
| int_type | input | 2 | Target integer type |
| cvt_mode | input | 3 | Out-of-range behaviour and forced truncation |
| rnd_mode | input | 2 | Dynamic rounding mode |
| inv_en | input | 1 | Invalid-operation trap enable |
| ovf_en | input | 1 | Integer overflow reporting enable |
| out_valid | output | 1 | Result stage holds a conversion |
| result | output | 64 | Converted integer |
| wr_en | output | 1 | Destination write enable |
| flag_inexact | output | 1 | Result lost precision |
| flag_rndup | output | 1 | Rounding increased the magnitude |
| flag_snan | output | 1 | Signalling NaN operand |
| flag_cvt_inv | output | 1 | Invalid conversion |
| ovf | output | 1 | Integer overflow |
| illegal_mode | output | 1 | Reserved mode code used |

## Verification
The datapath holds no state beyond its single output register. A wrong internal decision therefore shows up on the outputs in the very cycle after the operand is accepted. A wrong shift or round shows as a result off by one or by a power of two, with a mismatched inexact or rounded-up flag. A wrong range decision shows as a saturated value where a wrapped or exact one was due, or the other way round, usually together with a wrong invalid or overflow flag. The stimulus sits on the edges where these decisions turn: ties under every rounding mode, type minima and maxima, 2^31, 2^32 and 2^64, negative operands with unsigned targets, NaN kinds and infinities.

// File: rtl/fp2int_pkg.sv
package fp2int_pkg;

  typedef enum logic [1:0] {
    ITY_S32 = 2'd0,
    ITY_U32 = 2'd1,
    ITY_S64 = 2'd2,
    ITY_U64 = 2'd3
  } int_ty_e;

  typedef enum logic [1:0] {
    RM_NEAR = 2'd0,
    RM_ZERO = 2'd1,
    RM_UP   = 2'd2,
    RM_DOWN = 2'd3
  } rnd_e;

  typedef enum logic [1:0] {
    BH_HWSAT = 2'd0,
    BH_LGSAT = 2'd1,
    BH_WRAP  = 2'd2,
    BH_RSVD  = 2'd3
  } behav_e;

  // Increment decision for a truncated magnitude given guard and sticky bits.
  function automatic logic rnd_increment(input rnd_e rm, input logic neg,
                                         input logic lsb, input logic g,
                                         input logic s);
    logic inc;
    case (rm)
      RM_NEAR: inc = g & (s | lsb);
      RM_ZERO: inc = 1'b0;
      RM_UP:   inc = ~neg & (g | s);
      default: inc = neg & (g | s);
    endcase
    return inc;
  endfunction

endpackage

// File: rtl/fp2int_unpack.sv
module fp2int_unpack #(
  parameter int EXP_W      = 11,
  parameter int FRAC_W     = 52,
  parameter int SGL_FRAC_W = 23,
  localparam int FP_W      = 1 + EXP_W + FRAC_W,
  localparam int SIG_W     = FRAC_W + 1,
  localparam int DROP_W    = FRAC_W - SGL_FRAC_W
) (
  input  logic [FP_W-1:0]  op,
  input  logic             single_sel,
  output logic             sign,
  output logic [EXP_W-1:0] exp_eff,
  output logic [SIG_W-1:0] sig,
  output logic             is_nan,
  output logic             is_snan,
  output logic             is_inf
);

  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;
  logic [FRAC_W-1:0] frac_kept;
  logic              exp_max;
  logic              exp_zero;

  always_comb begin
    sign     = op[FP_W-1];
    exp_f    = op[FP_W-2:FRAC_W];
    frac_f   = op[FRAC_W-1:0];
    exp_max  = &exp_f;
    exp_zero = ~|exp_f;

    // Single-precision view drops the fraction bits it cannot hold.
    frac_kept = frac_f;
    if (single_sel)
      frac_kept[DROP_W-1:0] = '0;

    is_nan  = exp_max & (|frac_f);
    is_snan = is_nan & ~frac_f[FRAC_W-1];
    is_inf  = exp_max & ~(|frac_f);

    exp_eff = exp_zero ? EXP_W'(1) : exp_f;
    sig     = {~exp_zero, frac_kept};
  end

endmodule

// File: rtl/fp2int_align.sv
module fp2int_align
  import fp2int_pkg::*;
#(
  parameter int EXP_W     = 11,
  parameter int FRAC_W    = 52,
  parameter int OUT_W     = 64,
  localparam int SIG_W    = FRAC_W + 1,
  localparam int BIAS     = (1 << (EXP_W - 1)) - 1,
  localparam int PT       = BIAS + FRAC_W,
  localparam int SH_W     = EXP_W + 2,
  localparam int AMT_W    = $clog2(OUT_W + SIG_W + 4),
  localparam int WIDE_W   = OUT_W + SIG_W,
  localparam int EXT_W    = 2 * SIG_W + 2
) (
  input  logic [EXP_W-1:0] exp_eff,
  input  logic [SIG_W-1:0] sig,
  input  logic             sign,
  input  rnd_e             rm,
  output logic [OUT_W-1:0] mag,
  output logic             huge,
  output logic             inexact,
  output logic             rndup
);

  logic signed [SH_W-1:0] sh;
  logic signed [SH_W-1:0] rsh;
  logic [AMT_W-1:0]       amt;
  logic [WIDE_W-1:0]      wide;
  logic [EXT_W-1:0]       ext;
  logic [OUT_W-1:0]       trunc_mag;
  logic                   big;
  logic                   g;
  logic                   s;
  logic                   inc;
  logic [OUT_W:0]         sum;

  always_comb begin
    sh   = $signed({2'b00, exp_eff}) - $signed(SH_W'(PT));
    rsh  = -sh;
    amt  = '0;
    wide = '0;
    ext  = '0;
    g    = 1'b0;
    s    = 1'b0;
    big  = 1'b0;
    trunc_mag = '0;

    if (sh >= 0) begin
      // Integer operand: shift left, no fraction left over.
      if (sh > $signed(SH_W'(OUT_W))) begin
        big = 1'b1;
      end else begin
        amt  = AMT_W'(sh);
        wide = {{OUT_W{1'b0}}, sig} << amt;
        trunc_mag = wide[OUT_W-1:0];
        big  = |wide[WIDE_W-1:OUT_W];
      end
    end else begin
      // Fractional part present: shift right keeping guard and sticky.
      if (rsh > $signed(SH_W'(SIG_W + 1))) begin
        s = |sig;
      end else begin
        amt = AMT_W'(rsh);
        ext = {sig, {(SIG_W + 2){1'b0}}} >> amt;
        trunc_mag = {{(OUT_W - SIG_W){1'b0}}, ext[EXT_W-1:SIG_W+2]};
        g = ext[SIG_W+1];
        s = |ext[SIG_W:0];
      end
    end

    inc     = rnd_increment(rm, sign, trunc_mag[0], g, s);
    sum     = {1'b0, trunc_mag} + {{OUT_W{1'b0}}, inc};
    mag     = sum[OUT_W-1:0];
    huge    = big | sum[OUT_W];
    inexact = g | s;
    rndup   = inc;
  end

endmodule

// File: rtl/fp2int_select.sv
module fp2int_select
  import fp2int_pkg::*;
#(
  parameter int OUT_W   = 64,
  localparam int HALF_W = OUT_W / 2
) (
  input  behav_e           behav,
  input  int_ty_e          ity,
  input  logic             sign,
  input  logic [OUT_W-1:0] mag,
  input  logic             huge,
  input  logic             is_nan,
  input  logic             is_snan,
  input  logic             is_inf,
  input  logic             inexact_in,
  input  logic             rndup_in,
  output logic [OUT_W-1:0] res,
  output logic             snan_flag,
  output logic             cvt_inv,
  output logic             inexact_out,
  output logic             rndup_out,
  output logic             ovf_raw
);

  logic             sat;
  logic             nonzero;
  logic             over;
  logic             under;
  logic             oor;
  logic [OUT_W-1:0] raw;
  logic [OUT_W-1:0] ext;
  logic [OUT_W-1:0] maxv;
  logic [OUT_W-1:0] minv;

  always_comb begin
    sat     = (behav == BH_HWSAT) | (behav == BH_LGSAT);
    nonzero = huge | (|mag);
    raw     = sign ? (~mag + OUT_W'(1)) : mag;

    case (ity)
      ITY_S32: begin
        over  = ~sign & (huge | (|mag[OUT_W-1:HALF_W-1]));
        under = sign & (huge | (|mag[OUT_W-1:HALF_W]) |
                        (mag[HALF_W-1] & (|mag[HALF_W-2:0])));
        maxv  = {{(HALF_W + 1){1'b0}}, {(HALF_W - 1){1'b1}}};
        minv  = {{(HALF_W + 1){1'b1}}, {(HALF_W - 1){1'b0}}};
        ext   = {{HALF_W{raw[HALF_W-1]}}, raw[HALF_W-1:0]};
      end
      ITY_U32: begin
        over  = ~sign & (huge | (|mag[OUT_W-1:HALF_W]));
        under = sign & nonzero;
        maxv  = {{HALF_W{1'b0}}, {HALF_W{1'b1}}};
        minv  = '0;
        ext   = {{HALF_W{1'b0}}, raw[HALF_W-1:0]};
      end
      ITY_S64: begin
        over  = ~sign & (huge | mag[OUT_W-1]);
        under = sign & (huge | (mag[OUT_W-1] & (|mag[OUT_W-2:0])));
        maxv  = {1'b0, {(OUT_W - 1){1'b1}}};
        minv  = {1'b1, {(OUT_W - 1){1'b0}}};
        ext   = raw;
      end
      default: begin
        over  = ~sign & huge;
        under = sign & nonzero;
        maxv  = '1;
        minv  = '0;
        ext   = raw;
      end
    endcase

    oor = over | under;

    if (behav == BH_WRAP) begin
      res = (is_nan | is_inf) ? '0 : ext;
    end else if (is_nan) begin
      res = (behav == BH_HWSAT) ? minv : '0;
    end else if (over) begin
      res = maxv;
    end else if (under) begin
      res = minv;
    end else begin
      res = ext;
    end

    snan_flag   = is_snan;
    cvt_inv     = is_nan | (sat & oor);
    inexact_out = ~is_nan & inexact_in & ~(sat & oor);
    rndup_out   = ~is_nan & rndup_in & ~(sat & oor);
    ovf_raw     = is_nan | oor | inexact_in;
  end

endmodule

// File: rtl/fp2int_conv.sv
module fp2int_conv
  import fp2int_pkg::*;
#(
  parameter int EXP_W      = 11,
  parameter int FRAC_W     = 52,
  parameter int SGL_FRAC_W = 23,
  parameter int OUT_W      = 64,
  localparam int FP_W      = 1 + EXP_W + FRAC_W,
  localparam int SIG_W     = FRAC_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [FP_W-1:0]  op_bits,
  input  logic             single_sel,
  input  logic [1:0]       int_type,
  input  logic [2:0]       cvt_mode,
  input  logic [1:0]       rnd_mode,
  input  logic             inv_en,
  input  logic             ovf_en,
  output logic             out_valid,
  output logic [OUT_W-1:0] result,
  output logic             wr_en,
  output logic             flag_inexact,
  output logic             flag_rndup,
  output logic             flag_snan,
  output logic             flag_cvt_inv,
  output logic             ovf,
  output logic             illegal_mode
);

  logic             u_sign;
  logic [EXP_W-1:0] u_exp;
  logic [SIG_W-1:0] u_sig;
  logic             u_nan;
  logic             u_snan;
  logic             u_inf;
  rnd_e             rm_eff;
  behav_e           behav;
  logic [OUT_W-1:0] a_mag;
  logic             a_huge;
  logic             a_inexact;
  logic             a_rndup;
  logic [OUT_W-1:0] s_res;
  logic             s_snan;
  logic             s_inv;
  logic             s_inexact;
  logic             s_rndup;
  logic             s_ovf;
  logic             illegal_d;
  logic             trap_d;

  fp2int_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .SGL_FRAC_W(SGL_FRAC_W)) u_unpack (
    .op        (op_bits),
    .single_sel(single_sel),
    .sign      (u_sign),
    .exp_eff   (u_exp),
    .sig       (u_sig),
    .is_nan    (u_nan),
    .is_snan   (u_snan),
    .is_inf    (u_inf)
  );

  always_comb begin
    rm_eff    = cvt_mode[0] ? RM_ZERO : rnd_e'(rnd_mode);
    behav     = behav_e'(cvt_mode[2:1]);
    illegal_d = (behav == BH_RSVD);
  end

  fp2int_align #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .OUT_W(OUT_W)) u_align (
    .exp_eff(u_exp),
    .sig    (u_sig),
    .sign   (u_sign),
    .rm     (rm_eff),
    .mag    (a_mag),
    .huge   (a_huge),
    .inexact(a_inexact),
    .rndup  (a_rndup)
  );

  fp2int_select #(.OUT_W(OUT_W)) u_select (
    .behav      (behav),
    .ity        (int_ty_e'(int_type)),
    .sign       (u_sign),
    .mag        (a_mag),
    .huge       (a_huge),
    .is_nan     (u_nan),
    .is_snan    (u_snan),
    .is_inf     (u_inf),
    .inexact_in (a_inexact),
    .rndup_in   (a_rndup),
    .res        (s_res),
    .snan_flag  (s_snan),
    .cvt_inv    (s_inv),
    .inexact_out(s_inexact),
    .rndup_out  (s_rndup),
    .ovf_raw    (s_ovf)
  );

  assign trap_d = inv_en & (s_snan | s_inv);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid    <= 1'b0;
      result       <= '0;
      wr_en        <= 1'b0;
      flag_inexact <= 1'b0;
      flag_rndup   <= 1'b0;
      flag_snan    <= 1'b0;
      flag_cvt_inv <= 1'b0;
      ovf          <= 1'b0;
      illegal_mode <= 1'b0;
    end else begin
      out_valid    <= in_valid;
      illegal_mode <= in_valid & illegal_d;
      wr_en        <= in_valid & ~illegal_d & ~trap_d;
      flag_snan    <= in_valid & ~illegal_d & s_snan;
      flag_cvt_inv <= in_valid & ~illegal_d & s_inv;
      flag_inexact <= in_valid & ~illegal_d & ~trap_d & s_inexact;
      flag_rndup   <= in_valid & ~illegal_d & ~trap_d & s_rndup;
      ovf          <= in_valid & ~illegal_d & ~trap_d & ovf_en & s_ovf;
      if (in_valid)
        result <= illegal_d ? '0 : s_res;
    end
  end

  assert_valid_latency_R1: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  assert_wr_needs_valid_R1: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> out_valid);
  assert_illegal_nowrite_R7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && cvt_mode[2:1] == 2'b11) |=> (illegal_mode && !wr_en && !flag_cvt_inv));
  assert_rndup_inexact_R8: assert property (@(posedge clk) disable iff (rst)
    flag_rndup |-> flag_inexact);
  assert_nan_invalid_R9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && u_nan && !illegal_d) |=> flag_cvt_inv);
  assert_ovf_gated_R10: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !ovf_en) |=> !ovf);
  assert_trap_nowrite_R11: assert property (@(posedge clk) disable iff (rst)
    (in_valid && inv_en) |=> !(wr_en && (flag_snan || flag_cvt_inv)));

endmodule

// File: tb/test_fp2int_conv.sv
module test_fp2int_conv;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [63:0] op_bits;
  logic        single_sel;
  logic [1:0]  int_type;
  logic [2:0]  cvt_mode;
  logic [1:0]  rnd_mode;
  logic        inv_en;
  logic        ovf_en;
  logic        out_valid;
  logic [63:0] result;
  logic        wr_en;
  logic        flag_inexact;
  logic        flag_rndup;
  logic        flag_snan;
  logic        flag_cvt_inv;
  logic        ovf;
  logic        illegal_mode;

  always #5 clk = ~clk;

  fp2int_conv i_fp2int_conv (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_bits(op_bits),
    .single_sel(single_sel), .int_type(int_type), .cvt_mode(cvt_mode),
    .rnd_mode(rnd_mode), .inv_en(inv_en), .ovf_en(ovf_en),
    .out_valid(out_valid), .result(result), .wr_en(wr_en),
    .flag_inexact(flag_inexact), .flag_rndup(flag_rndup),
    .flag_snan(flag_snan), .flag_cvt_inv(flag_cvt_inv), .ovf(ovf),
    .illegal_mode(illegal_mode)
  );

  typedef struct {
    logic [63:0] res;
    logic        wr;
    logic [5:0]  flags; // {inexact, rndup, snan, cvt_inv, ovf, illegal}
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0;
  int   errors = 0;
  bit   done   = 1'b0;

  localparam logic [63:0] D_ONE   = 64'h3FF0000000000000;
  localparam logic [63:0] D_1P5   = 64'h3FF8000000000000;
  localparam logic [63:0] D_M1P5  = 64'hBFF8000000000000;
  localparam logic [63:0] D_2P5   = 64'h4004000000000000;
  localparam logic [63:0] D_M2P5  = 64'hC004000000000000;
  localparam logic [63:0] D_M1    = 64'hBFF0000000000000;
  localparam logic [63:0] D_M3    = 64'hC008000000000000;
  localparam logic [63:0] D_MZERO = 64'h8000000000000000;
  localparam logic [63:0] D_QNAN  = 64'h7FF8000000000000;
  localparam logic [63:0] D_SNAN  = 64'h7FF0000000000001;
  localparam logic [63:0] D_PINF  = 64'h7FF0000000000000;
  localparam logic [63:0] D_P2_31 = 64'h41E0000000000000;
  localparam logic [63:0] D_M2_31 = 64'hC1E0000000000000;
  localparam logic [63:0] D_P2_64 = 64'h43F0000000000000;
  localparam logic [63:0] D_3E9   = 64'h41E65A0BC0000000;
  localparam logic [63:0] D_2_32P5 = 64'h41F0000000500000;
  localparam logic [63:0] D_ONE_TINY = 64'h3FF0000000001000;

  task automatic send(input logic [63:0] op, input logic [1:0] ity,
                      input logic [2:0] md, input logic [1:0] rm,
                      input logic inv, input logic oe, input logic sgl,
                      input logic [63:0] e_res, input logic e_wr,
                      input logic [5:0] e_flags, input string tag);
    exp_t e;
    op_bits = op; int_type = ity; cvt_mode = md; rnd_mode = rm;
    inv_en = inv; ovf_en = oe; single_sel = sgl; in_valid = 1'b1;
    e.res = e_res; e.wr = e_wr; e.flags = e_flags; e.tag = tag;
    exp_q.push_back(e);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // Monitor: compares each produced result with the oldest expectation.
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      logic [5:0] got;
      exp_t e;
      got = {flag_inexact, flag_rndup, flag_snan, flag_cvt_inv, ovf, illegal_mode};
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R1 unexpected result actual=%h expected none", result);
      end else begin
        e = exp_q.pop_front();
        if (result !== e.res || wr_en !== e.wr || got !== e.flags) begin
          errors++;
          $display("FAIL %s actual res=%h wr=%b flags=%b expected res=%h wr=%b flags=%b",
                   e.tag, result, wr_en, got, e.res, e.wr, e.flags);
        end
      end
    end
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0; op_bits = '0; single_sel = 1'b0;
    int_type = 2'd0; cvt_mode = 3'd0; rnd_mode = 2'd0; inv_en = 1'b0; ovf_en = 1'b0;
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || wr_en !== 1'b0 || result !== 64'd0 || ovf !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset state actual v=%b wr=%b res=%h expected 0 0 0",
               out_valid, wr_en, result);
    end
    rst = 1'b0;
    @(negedge clk);

    // R2 types and extension
    send(D_ONE,  2'd2, 3'b000, 2'd0, 0, 1, 0, 64'd1, 1, 6'b000000, "R2 s64 one");
    send(D_M3,   2'd0, 3'b001, 2'd0, 0, 0, 0, 64'hFFFFFFFFFFFFFFFD, 1, 6'b000000, "R2 s32 sign-extend");
    send(D_3E9,  2'd1, 3'b000, 2'd0, 0, 0, 0, 64'h00000000B2D05E00, 1, 6'b000000, "R2 u32 zero-extend");
    // R3 rounding modes, R8 flags
    send(D_2P5,  2'd0, 3'b000, 2'd0, 0, 0, 0, 64'd2, 1, 6'b100000, "R3 nearest-even tie down");
    send(D_1P5,  2'd0, 3'b000, 2'd0, 0, 0, 0, 64'd2, 1, 6'b110000, "R3 R8 nearest-even tie up");
    send(D_2P5,  2'd0, 3'b000, 2'd2, 0, 0, 0, 64'd3, 1, 6'b110000, "R3 toward +inf");
    send(D_M2P5, 2'd0, 3'b000, 2'd2, 0, 0, 0, 64'hFFFFFFFFFFFFFFFE, 1, 6'b100000, "R3 R8 negative toward +inf");
    send(D_M2P5, 2'd0, 3'b000, 2'd3, 0, 0, 0, 64'hFFFFFFFFFFFFFFFD, 1, 6'b110000, "R3 toward -inf");
    send(D_2P5,  2'd0, 3'b001, 2'd2, 0, 0, 0, 64'd2, 1, 6'b100000, "R3 forced truncation");
    send(D_M1P5, 2'd0, 3'b000, 2'd1, 0, 0, 0, 64'hFFFFFFFFFFFFFFFF, 1, 6'b100000, "R3 toward zero");
    // R13 exact values
    send(D_MZERO, 2'd2, 3'b000, 2'd0, 0, 1, 0, 64'd0, 1, 6'b000000, "R13 negative zero");
    send(D_M2_31, 2'd0, 3'b000, 2'd0, 0, 1, 0, 64'hFFFFFFFF80000000, 1, 6'b000000, "R13 s32 minimum exact");
    // R4 hardware saturation
    send(D_QNAN, 2'd0, 3'b000, 2'd0, 0, 0, 0, 64'hFFFFFFFF80000000, 1, 6'b000100, "R4 NaN to s32 min");
    send(D_QNAN, 2'd3, 3'b000, 2'd0, 0, 0, 0, 64'd0, 1, 6'b000100, "R4 NaN to u64 min");
    send(D_3E9,  2'd0, 3'b000, 2'd0, 0, 0, 0, 64'h000000007FFFFFFF, 1, 6'b000100, "R4 s32 above max");
    send(D_P2_31, 2'd0, 3'b000, 2'd0, 0, 1, 0, 64'h000000007FFFFFFF, 1, 6'b000110, "R4 R10 2^31 saturates");
    send(D_P2_64, 2'd3, 3'b000, 2'd0, 0, 0, 0, 64'hFFFFFFFFFFFFFFFF, 1, 6'b000100, "R4 u64 above max");
    // R5 language saturation
    send(D_QNAN, 2'd2, 3'b010, 2'd0, 0, 1, 0, 64'd0, 1, 6'b000110, "R5 R10 NaN to zero");
    send(D_M1,   2'd1, 3'b011, 2'd0, 0, 0, 0, 64'd0, 1, 6'b000100, "R5 u32 below min");
    // R6 modular wrap
    send(D_M1,   2'd1, 3'b100, 2'd0, 0, 1, 0, 64'h00000000FFFFFFFF, 1, 6'b000010, "R6 u32 wrap of -1");
    send(D_3E9,  2'd0, 3'b100, 2'd0, 0, 0, 0, 64'hFFFFFFFFB2D05E00, 1, 6'b000000, "R6 s32 wrap negative");
    send(D_2_32P5, 2'd0, 3'b101, 2'd0, 0, 0, 0, 64'd5, 1, 6'b000000, "R6 modulo 2^32");
    send(D_PINF, 2'd2, 3'b100, 2'd0, 0, 1, 0, 64'd0, 1, 6'b000010, "R6 infinity to zero");
    send(D_QNAN, 2'd3, 3'b100, 2'd0, 0, 0, 0, 64'd0, 1, 6'b000100, "R6 R9 NaN to zero");
    // R9 signalling NaN
    send(D_SNAN, 2'd2, 3'b000, 2'd0, 0, 0, 0, 64'h8000000000000000, 1, 6'b001100, "R9 signalling NaN");
    // R11 invalid trap
    send(D_SNAN, 2'd2, 3'b000, 2'd0, 1, 1, 0, 64'h8000000000000000, 0, 6'b001100, "R11 trap on sNaN");
    send(D_3E9,  2'd0, 3'b000, 2'd0, 1, 1, 0, 64'h000000007FFFFFFF, 0, 6'b000100, "R11 trap on range");
    // R7 reserved modes
    send(D_2P5,  2'd0, 3'b110, 2'd0, 0, 0, 0, 64'd0, 0, 6'b000001, "R7 mode 110");
    send(D_2P5,  2'd0, 3'b111, 2'd0, 1, 1, 0, 64'd0, 0, 6'b000001, "R7 mode 111");
    // R12 single-precision view
    send(D_ONE_TINY, 2'd2, 3'b001, 2'd0, 0, 1, 0, 64'd1, 1, 6'b100010, "R12 double keeps low fraction");
    send(D_ONE_TINY, 2'd2, 3'b001, 2'd0, 0, 1, 1, 64'd1, 1, 6'b000000, "R12 single drops low fraction");
    // R10 gating
    send(D_1P5,  2'd0, 3'b000, 2'd1, 0, 1, 0, 64'd1, 1, 6'b100010, "R10 inexact overflow");
    send(D_1P5,  2'd0, 3'b000, 2'd1, 0, 0, 0, 64'd1, 1, 6'b100000, "R10 overflow disabled");

    repeat (4) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R1 results missing actual=%0d expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog expired actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule